// File: doc/BRIEF.md
# Segment Display, Status LED and Key Panel Controller

This block is a small bus-mapped peripheral that a host reaches through an asynchronous strobe interface, much like a tiny static RAM. The host writes raw segment bitmaps into four digit registers and a nibble into a status-LED register. It reads back the live state of four push buttons through the same data lines. The controller scans the four digits of a multiplexed seven-segment display, lighting one digit at a time from a divided system clock.

The data bus appears at the block edge as an input, an output value and a per-bit output enable, so that the pad ring builds the bidirectional pins. Only the low four lines are ever enabled. The upper four are left to the board pull-ups and read as ones. An active-low device-wide clear brings every register to zero.

Top module: `seg_panel_ctrl`

## Requirements
- R1: While and after the active-low clear, all four digit registers and the LED register are zero and digit 0 is the enabled digit.
- R2: A write with select 0, 1, 2 or 3 stores all eight data bits in that digit register. Bit n drives segment line n, bit 7 is the decimal point, and a 1 lights the segment. The value appears on the segment outputs while that digit is enabled.
- R3: A write with select 4 stores data bits 3..0 in the LED register, where a 1 turns an LED on. Data bits 7..4 have no effect on it.
- R4: A write with select 5, 6 or 7 changes no digit register and no LED state.
- R5: During a read, data lines 3..0 are driven with the synchronised button states, where 1 means pressed. Lines 7..4 are never enabled and carry the value 1 for the pull-ups.
- R6: The select lines have no effect on the value returned by a read.
- R7: The data lines are enabled only while the read strobe is low and the write strobe is high.
- R8: Exactly one of the four digit enables is high at any time, and they step in the order 0, 1, 2, 3, 0.
- R9: The enabled digit advances once every 2^DIV_W clock cycles (65536 by default).
- R10: A write takes effect only after the write strobe rises. While the strobe is held low, the stored registers keep their old values.
- R11: A button change reaches the read data after two clock edges and not after one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (scan source) |
| rst_n | input | 1 | Active-low device-wide clear |
| wr_n | input | 1 | Active-low write strobe, asynchronous |
| rd_n | input | 1 | Active-low read strobe, asynchronous |
| sel_i | input | 3 | Register select |
| data_i | input | 8 | Data bus value seen at the pads |
| data_o | output | 8 | Value driven onto the data bus |
| data_oe | output | 8 | Per-line output enable for the data bus |
| keys_i | input | 4 | Raw button inputs, 1 = pressed |
| digit_en_o | output | 4 | One-hot digit enable for the display |
| seg_o | output | 8 | Segment drive for the enabled digit |
| led_o | output | 4 | Status LED drive |

## Verification
A wrong scan index or prescaler shows up as a missing, repeated or mistimed digit enable within one scan period, and the segment outputs then show some other digit's bitmap. A corrupted register or a misdecoded select only becomes visible when that digit's turn in the scan arrives, so the bench always watches a full rotation, four prescaler periods, after each write. Errors in the read path appear at once on the enables and the key nibble. A broken synchroniser appears as a one-edge shift in the button latency.

// File: rtl/seg_panel_pkg.sv
package seg_panel_pkg;
  localparam int DATA_W = 8;
  localparam int SEL_W  = 3;
  localparam int N_DIG  = 4;
  localparam int N_LED  = 4;
  localparam int N_KEY  = 4;
  localparam int IDX_W  = $clog2(N_DIG);
  localparam logic [SEL_W-1:0] LED_SEL = 3'd4;

  typedef logic [DATA_W-1:0] seg_t;

  // scan order: ascending, wrapping after the last digit
  function automatic logic [IDX_W-1:0] next_digit(input logic [IDX_W-1:0] cur);
    return (cur == IDX_W'(N_DIG - 1)) ? '0 : cur + 1'b1;
  endfunction

  function automatic logic sel_hits_digit(input logic [SEL_W-1:0] s);
    return s < SEL_W'(N_DIG);
  endfunction
endpackage

// File: rtl/wr_strobe_sync.sv
module wr_strobe_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_n,
  output logic commit
);
  logic meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b1;
      sync_q <= 1'b1;
      prev_q <= 1'b1;
    end else begin
      meta_q <= wr_n;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  // deasserting edge of the strobe, in the clock domain
  assign commit = sync_q & ~prev_q;

  p_commit_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !commit);
endmodule

// File: rtl/key_sync.sv
module key_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] stage1_q, stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= raw_i;
      stage2_q <= stage1_q;
    end
  end

  assign sync_o = stage2_q;
endmodule

// File: rtl/panel_regs.sv
module panel_regs
  import seg_panel_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   commit,
  input  logic [SEL_W-1:0]       sel_i,
  input  logic [DATA_W-1:0]      data_i,
  output seg_t [N_DIG-1:0]       digits_o,
  output logic [N_LED-1:0]       led_o
);
  logic hit_led;
  assign hit_led = commit && (sel_i == LED_SEL);

  for (genvar g = 0; g < N_DIG; g++) begin : g_digit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        digits_o[g] <= '0;
      else if (commit && sel_hits_digit(sel_i) && sel_i == SEL_W'(g))
        digits_o[g] <= data_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      led_o <= '0;
    else if (hit_led) led_o <= data_i[N_LED-1:0];
  end

  p_ignore_high_sel_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && sel_i > LED_SEL) |=> ($stable(digits_o) && $stable(led_o)));

  p_led_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && sel_i == LED_SEL) |=> (led_o == $past(data_i[N_LED-1:0]) && $stable(digits_o)));

  p_hold_without_commit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> ($stable(digits_o) && $stable(led_o)));
endmodule

// File: rtl/scan_driver.sv
module scan_driver
  import seg_panel_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [IDX_W-1:0] idx_o,
  output logic [N_DIG-1:0] digit_en_o
);
  logic [DIV_W-1:0] pre_q;
  logic             tick;

  assign tick = (pre_q == {DIV_W{1'b1}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      idx_o <= '0;
    end else begin
      pre_q <= pre_q + 1'b1;
      if (tick) idx_o <= next_digit(idx_o);
    end
  end

  for (genvar g = 0; g < N_DIG; g++) begin : g_en
    assign digit_en_o[g] = (idx_o == IDX_W'(g));
  end

  p_digit_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(digit_en_o));

  p_scan_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(digit_en_o));

  p_scan_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (idx_o == next_digit($past(idx_o))));
endmodule

// File: rtl/seg_panel_ctrl.sv
module seg_panel_ctrl
  import seg_panel_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_n,
  input  logic              rd_n,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic [DATA_W-1:0] data_oe,
  input  logic [N_KEY-1:0]  keys_i,
  output logic [N_DIG-1:0]  digit_en_o,
  output logic [DATA_W-1:0] seg_o,
  output logic [N_LED-1:0]  led_o
);
  logic             commit;
  logic [N_KEY-1:0] keys_s;
  seg_t [N_DIG-1:0] digits;
  logic [IDX_W-1:0] scan_idx;
  logic             rd_active;

  wr_strobe_sync u_wr (
    .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .commit(commit)
  );

  key_sync #(.W(N_KEY)) u_keys (
    .clk(clk), .rst_n(rst_n), .raw_i(keys_i), .sync_o(keys_s)
  );

  panel_regs u_regs (
    .clk(clk), .rst_n(rst_n), .commit(commit), .sel_i(sel_i),
    .data_i(data_i), .digits_o(digits), .led_o(led_o)
  );

  scan_driver #(.DIV_W(DIV_W)) u_scan (
    .clk(clk), .rst_n(rst_n), .idx_o(scan_idx), .digit_en_o(digit_en_o)
  );

  assign seg_o = digits[scan_idx];

  // read path: strobe-qualified, select not decoded
  assign rd_active = ~rd_n & wr_n;
  assign data_o    = {{(DATA_W-N_KEY){1'b1}}, keys_s};
  assign data_oe   = {{(DATA_W-N_KEY){1'b0}}, {N_KEY{rd_active}}};

  p_no_drive_on_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> (data_oe == '0));

  p_seg_matches_enabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (digit_en_o[0] |-> seg_o == digits[0]));
endmodule

// File: tb/tb_seg_panel_ctrl.sv
`timescale 1ns/1ps
module tb_seg_panel_ctrl;
  localparam int DIV_W = 3;
  localparam int PERIOD = 1 << DIV_W;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_n = 1'b1, rd_n = 1'b1;
  logic [2:0] sel_i = '0;
  logic [7:0] data_i = '0;
  logic [7:0] data_o, data_oe, seg_o;
  logic [3:0] keys_i = '0, digit_en_o, led_o;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [7:0] exp_dig [4];
  logic [3:0] exp_led;

  always #2 clk = ~clk;

  seg_panel_ctrl #(.DIV_W(DIV_W)) dut (
    .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .rd_n(rd_n), .sel_i(sel_i),
    .data_i(data_i), .data_o(data_o), .data_oe(data_oe), .keys_i(keys_i),
    .digit_en_o(digit_en_o), .seg_o(seg_o), .led_o(led_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // bus value as seen at the pins: undriven lines pulled to 1
  function automatic logic [7:0] bus_view();
    logic [7:0] v;
    for (int b = 0; b < 8; b++) v[b] = data_oe[b] ? data_o[b] : 1'b1;
    return v;
  endfunction

  task automatic bus_write(input logic [2:0] s, input logic [7:0] d);
    @(negedge clk); sel_i = s; data_i = d; wr_n = 0;
    repeat (3) @(negedge clk);
    wr_n = 1;
    repeat (5) @(negedge clk);
    data_i = ~d; sel_i = s + 3'd3;
    if (s < 4) exp_dig[s] = d;
    else if (s == 4) exp_led = d[3:0];
  endtask

  // watch a full rotation and compare each digit once
  task automatic check_display(input string req);
    bit seen [4];
    bit bad_hot = 0;
    for (int i = 0; i < 4; i++) seen[i] = 0;
    for (int c = 0; c < 4 * PERIOD + 4; c++) begin
      @(negedge clk);
      if (!$onehot(digit_en_o)) bad_hot = 1;
      for (int i = 0; i < 4; i++)
        if (digit_en_o == 4'(1 << i) && !seen[i]) begin
          seen[i] = 1;
          chk(seg_o == exp_dig[i], req, seg_o, exp_dig[i]);
        end
    end
    chk(!bad_hot, "R8 onehot", digit_en_o, 0);
    chk(led_o == exp_led, req, led_o, exp_led);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) exp_dig[i] = '0;
    exp_led = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(digit_en_o == 4'b0001, "R1 scan", digit_en_o, 1);
    chk(led_o == 0 && seg_o == 0, "R1 regs", {led_o, seg_o}, 0);
    rst_n = 1;
    check_display("R1 cleared");

    // R8/R9: order and period of the scan
    begin
      logic [3:0] prev;
      int cnt;
      @(negedge clk);
      while (digit_en_o == 4'b0001 || digit_en_o == 4'b0000) @(negedge clk);
      prev = digit_en_o;
      for (int t = 0; t < 6; t++) begin
        cnt = 0;
        while (digit_en_o == prev && cnt < 100) begin @(negedge clk); cnt++; end
        chk(cnt == PERIOD, "R9 period", cnt, PERIOD);
        chk(digit_en_o == {prev[2:0], prev[3]}, "R8 order", digit_en_o, {prev[2:0], prev[3]});
        prev = digit_en_o;
      end
    end

    // R2: digit bitmaps, several patterns
    bus_write(0, 8'h3F); bus_write(1, 8'h86); bus_write(2, 8'hDB); bus_write(3, 8'h80);
    check_display("R2 digits");
    for (int p = 0; p < 4; p++) bus_write(3'(p), 8'(8'hA5 ^ (p * 8'h33)));
    check_display("R2 digits pattern2");

    // R3: LED, upper data bits ignored
    bus_write(4, 8'hF5);
    check_display("R3 led");
    chk(led_o == 4'h5, "R3 led value", led_o, 5);
    bus_write(4, 8'h0A);
    chk(led_o == 4'hA, "R3 led value2", led_o, 10);

    // R4: selects 5..7 do nothing
    for (int s = 5; s < 8; s++) begin
      @(negedge clk); sel_i = 3'(s); data_i = 8'hFF; wr_n = 0;
      repeat (3) @(negedge clk); wr_n = 1; repeat (5) @(negedge clk);
    end
    check_display("R4 ignored");

    // R10: held strobe changes nothing until release
    @(negedge clk); sel_i = 1; data_i = 8'h5A; wr_n = 0;
    check_display("R10 held");
    wr_n = 1; repeat (5) @(negedge clk);
    exp_dig[1] = 8'h5A;
    check_display("R10 released");

    // R7: idle and write do not drive
    @(negedge clk); #1;
    chk(data_oe == 0, "R7 idle", data_oe, 0);
    wr_n = 0; rd_n = 0; #1;
    chk(data_oe == 0, "R7 both low", data_oe, 0);
    @(negedge clk); wr_n = 1; rd_n = 1;

    // R5/R6: all key patterns, all selects
    for (int k = 0; k < 16; k++) begin
      @(negedge clk); keys_i = 4'(k);
      repeat (2) @(negedge clk);
      for (int s = 0; s < 8; s++) begin
        sel_i = 3'(s); rd_n = 0; #1;
        chk(bus_view() == {4'hF, 4'(k)}, "R5 R6 read", bus_view(), {4'hF, 4'(k)});
        chk(data_oe[7:4] == 0, "R5 upper", data_oe, 8'h0F);
        rd_n = 1; #1;
        chk(data_oe == 0, "R7 after read", data_oe, 0);
      end
    end

    // R11: synchroniser latency
    rd_n = 0;
    @(negedge clk); keys_i = 4'h6;
    @(negedge clk);
    chk(bus_view()[3:0] == 4'hF, "R11 one edge", bus_view(), 8'hFF);
    @(negedge clk);
    chk(bus_view()[3:0] == 4'h6, "R11 two edges", bus_view(), 8'hF6);
    rd_n = 1;

    // R1: clear again mid-run
    @(negedge clk); rst_n = 0; #1;
    chk(led_o == 0 && digit_en_o == 1 && seg_o == 0, "R1 reclear", {led_o, digit_en_o, seg_o}, 16'h0100);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule